// File: doc/BRIEF.md
# Reset Source and Generation Controller

This block manages resets for a four-processor system. Software reaches it through a byte-wide register port with a combinational read path. Through that port it can start a power-on-style reset on any subset of processors or on the whole system. It can also send an interrupt-style reset to chosen processors.

The block also watches several external reset requests: a watchdog-expiry line that software can gate, a push-button, a debug port, a remote monitor, fatal-error reports from seven agents, and a clock-synthesizer load that has been armed for reset. Each generated reset output is a pulse of fixed length. The block keeps a vector of the events that caused the most recent reset and a separate vector of the origins of the most recent interrupt-reset.

External requests act on their rising edge. Several requests that arrive in the same cycle are recorded together. The active-low asynchronous reset `rst_n` is released inside the block through a two-stage synchronizer.

Top module: `rstctl`

## Requirements
- R1: After reset release, all reset outputs are low, offsets 0-3 read 0x00, and the cause vector holds only bit 7 (power-up), so offset 4 reads 0x80 and offsets 5-7 read 0x00.
- R2: Writing offset 0 with bits 0-3 set raises `cpu_por_o` for exactly those processors, starting the cycle after the write and lasting 16 cycles. The cause vector is then replaced by those bits.
- R3: Writing offset 0 with bit 4 set raises `sys_por_o` and all four `cpu_por_o` for 16 cycles and replaces the cause vector with bit 4 alone.
- R4: A soft request bit at offset 0 or offset 1 reads back 1 while its pulse runs and clears itself when the pulse ends. Writing 0 to a running bit does not shorten its pulse.
- R5: Bit 0 of offset 2 enables the watchdog. With it set, a watchdog rising edge starts a system reset and sets cause bit 16. With it clear, the edge leaves the outputs and the cause vector unchanged.
- R6: A rising edge on the debug, push-button, remote-monitor or fatal-error[k] input starts a system reset. It sets cause bit 5, 6, 17 or 8+k respectively. Events in the same cycle are OR-ed into a cause vector that replaces the old one.
- R7: Writing offset 3 starts a system reset and sets cause bit 15 only when the written bits 7 and 0 are both 1 and the stored load bit (bit 0) was 0. Otherwise no reset occurs.
- R8: Writing offset 1 with bits 0-3 set raises `cpu_xir_o` for those processors for 16 cycles. The interrupt-reset source vector (offset 7) is replaced with those bits.
- R9: A rising edge on `dbg_xir_i` or `btn_xir_i` raises all four `cpu_xir_o` for 16 cycles and sets source bit 4 or bit 5 respectively.
- R10: Reserved bits read as 0 and ignore writes. Offset 0 uses bits 4:0, offset 1 bits 3:0, offset 2 bit 0, and offset 3 bits 7 and 0. Writes to offsets 4-7 have no effect.
- R11: The cause vector reads as bits 7:0 at offset 4, bits 15:8 at offset 5, and bits 17:16 in bits 1:0 of offset 6. The source vector reads in bits 5:0 of offset 7.
- R12: A new trigger for a pulse that is already running restarts its 16-cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| wdog_expire_i | input | 1 | Watchdog expiry request |
| btn_rst_i | input | 1 | Push-button system reset request |
| dbg_rst_i | input | 1 | Debug-port system reset request |
| remote_rst_i | input | 1 | Remote-monitor system reset request |
| fatal_err_i | input | 7 | Fatal-error reports; bits 0-3 are processors 0-3 |
| dbg_xir_i | input | 1 | Debug-port interrupt-reset to all processors |
| btn_xir_i | input | 1 | Button/watchdog interrupt-reset to all processors |
| cpu_por_o | output | 4 | Per-processor power-on reset pulse |
| sys_por_o | output | 1 | System reset pulse |
| cpu_xir_o | output | 4 | Per-processor interrupt-reset pulse |

## Verification
The bench sweeps every non-zero processor mask through both soft registers and every fatal-error input. For each case it checks the pulse width and the recorded vectors, which catches a counter that is off by one cycle or a mask bit that lands in the wrong place. It drives the watchdog with its enable off and then on; a design that failed to gate the watchdog would either reset the system or overwrite the cause vector. It also writes 0 to a running request, retriggers a running pulse, fires two events in the same cycle, and writes the synthesizer register with the load bit already set. A design that cancelled on the write of 0, failed to restart on retrigger, kept only one of two simultaneous events, or triggered on a level instead of an edge would show a pulse of the wrong width or a wrong cause value.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
  localparam int unsigned CPU_N   = 4;
  localparam int unsigned FATAL_N = 7;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned CAUSE_W = 18;
  localparam int unsigned XSRC_W  = CPU_N + 2;
  localparam int unsigned EXT_W   = 6 + FATAL_N;

  localparam logic [ADDR_W-1:0] A_SOFT_POR = 3'd0;
  localparam logic [ADDR_W-1:0] A_SOFT_XIR = 3'd1;
  localparam logic [ADDR_W-1:0] A_WD_CTL   = 3'd2;
  localparam logic [ADDR_W-1:0] A_SYNTH    = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAUSE0   = 3'd4;
  localparam logic [ADDR_W-1:0] A_CAUSE1   = 3'd5;
  localparam logic [ADDR_W-1:0] A_CAUSE2   = 3'd6;
  localparam logic [ADDR_W-1:0] A_XSRC     = 3'd7;

  localparam int unsigned C_SOFT_SYS = CPU_N;
  localparam int unsigned C_DBG      = 5;
  localparam int unsigned C_BTN      = 6;
  localparam int unsigned C_PWR      = 7;
  localparam int unsigned C_FATAL0   = 8;
  localparam int unsigned C_SYNTH    = 15;
  localparam int unsigned C_WDOG     = 16;
  localparam int unsigned C_REMOTE   = 17;

  localparam int unsigned X_DBG = CPU_N;
  localparam int unsigned X_BTN = CPU_N + 1;

  localparam int unsigned E_WDOG    = 0;
  localparam int unsigned E_BTN     = 1;
  localparam int unsigned E_DBG     = 2;
  localparam int unsigned E_REMOTE  = 3;
  localparam int unsigned E_DBG_XIR = 4;
  localparam int unsigned E_BTN_XIR = 5;
  localparam int unsigned E_FATAL0  = 6;
endpackage

// File: rtl/rstctl_edge.sv
module rstctl_edge #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] rise
);
  logic [W-1:0] d_q;
  logic [W-1:0] d_d;

  always_comb begin
    d_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) d_q <= '0;
    else        d_q <= d_d;
  end

  assign rise = d & ~d_q;
endmodule

// File: rtl/rstctl_pulse.sv
module rstctl_pulse #(
  parameter int unsigned LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic active,
  output logic done
);
  localparam int unsigned CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(LEN);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en = trig | (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (trig)               cnt_d = LOAD;
    else if (cnt_q != '0)   cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);
  assign done   = (cnt_q == ONE) && !trig;

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> active); // R12
  AST_PULSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && !active) |=> !active); // R2
  AST_PULSE_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !active); // R2
endmodule

// File: rtl/rstctl_regs.sv
module rstctl_regs
  import rstctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic [CPU_N:0]     por_done,
  input  logic [CPU_N-1:0]   xir_done,
  input  logic [CAUSE_W-1:0] cause_q,
  input  logic [XSRC_W-1:0]  xsrc_q,
  output logic [CPU_N:0]     por_req,
  output logic [CPU_N-1:0]   xir_req,
  output logic               synth_trig,
  output logic               wd_en,
  output logic [DATA_W-1:0]  reg_rdata
);
  logic [CPU_N:0]   soft_por_q, soft_por_d;
  logic [CPU_N-1:0] soft_xir_q, soft_xir_d;
  logic             wd_q, wd_d;
  logic             syn_arm_q, syn_arm_d;
  logic             syn_load_q, syn_load_d;
  logic             wr_por, wr_xir, wr_wd, wr_syn;
  logic             unused_wdata;

  assign wr_por = reg_wr && (reg_addr == A_SOFT_POR);
  assign wr_xir = reg_wr && (reg_addr == A_SOFT_XIR);
  assign wr_wd  = reg_wr && (reg_addr == A_WD_CTL);
  assign wr_syn = reg_wr && (reg_addr == A_SYNTH);
  assign unused_wdata = ^reg_wdata[6:5];

  assign por_req    = wr_por ? reg_wdata[CPU_N:0]   : '0;
  assign xir_req    = wr_xir ? reg_wdata[CPU_N-1:0] : '0;
  assign synth_trig = wr_syn && reg_wdata[7] && reg_wdata[0] && !syn_load_q;

  always_comb begin
    soft_por_d = (soft_por_q & ~por_done) | por_req;
    soft_xir_d = (soft_xir_q & ~xir_done) | xir_req;
    wd_d       = wr_wd  ? reg_wdata[0] : wd_q;
    syn_arm_d  = wr_syn ? reg_wdata[7] : syn_arm_q;
    syn_load_d = wr_syn ? reg_wdata[0] : syn_load_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_por_q <= '0;
      soft_xir_q <= '0;
      wd_q       <= 1'b0;
      syn_arm_q  <= 1'b0;
      syn_load_q <= 1'b0;
    end else begin
      soft_por_q <= soft_por_d;
      soft_xir_q <= soft_xir_d;
      if (wr_wd)  wd_q       <= wd_d;
      if (wr_syn) syn_arm_q  <= syn_arm_d;
      if (wr_syn) syn_load_q <= syn_load_d;
    end
  end

  assign wd_en = wd_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_SOFT_POR: reg_rdata = {{(DATA_W-CPU_N-1){1'b0}}, soft_por_q};
      A_SOFT_XIR: reg_rdata = {{(DATA_W-CPU_N){1'b0}}, soft_xir_q};
      A_WD_CTL:   reg_rdata = {{(DATA_W-1){1'b0}}, wd_q};
      A_SYNTH:    reg_rdata = {syn_arm_q, {(DATA_W-2){1'b0}}, syn_load_q};
      A_CAUSE0:   reg_rdata = cause_q[7:0];
      A_CAUSE1:   reg_rdata = cause_q[15:8];
      A_CAUSE2:   reg_rdata = {{(DATA_W-2){1'b0}}, cause_q[17:16]};
      A_XSRC:     reg_rdata = {{(DATA_W-XSRC_W){1'b0}}, xsrc_q};
      default:    reg_rdata = '0;
    endcase
  end

  AST_SOFT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_por |=> ((soft_por_q & $past(reg_wdata[CPU_N:0])) == $past(reg_wdata[CPU_N:0]))); // R4
  AST_RO_SYNTH: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_syn |=> $stable(syn_load_q)); // R10
endmodule

// File: rtl/rstctl_capture.sv
module rstctl_capture
  import rstctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_W-1:0] cause_evt,
  input  logic [XSRC_W-1:0]  xir_evt,
  output logic [CAUSE_W-1:0] cause_q,
  output logic [XSRC_W-1:0]  xsrc_q
);
  localparam logic [CAUSE_W-1:0] CAUSE_RST = CAUSE_W'(1) << C_PWR;

  logic [CAUSE_W-1:0] cause_d;
  logic [XSRC_W-1:0]  xsrc_d;
  logic               cause_en, xsrc_en;

  assign cause_en = |cause_evt;
  assign xsrc_en  = |xir_evt;

  always_comb begin
    cause_d = cause_evt;
    xsrc_d  = xir_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= CAUSE_RST;
      xsrc_q  <= '0;
    end else begin
      if (cause_en) cause_q <= cause_d;
      if (xsrc_en)  xsrc_q  <= xsrc_d;
    end
  end

  AST_PWR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    cause_q[C_PWR] |-> ($countones(cause_q) == 1)); // R1
endmodule

// File: rtl/rstctl.sv
module rstctl
  import rstctl_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                wdog_expire_i,
  input  logic                btn_rst_i,
  input  logic                dbg_rst_i,
  input  logic                remote_rst_i,
  input  logic [FATAL_N-1:0]  fatal_err_i,
  input  logic                dbg_xir_i,
  input  logic                btn_xir_i,
  output logic [CPU_N-1:0]    cpu_por_o,
  output logic                sys_por_o,
  output logic [CPU_N-1:0]    cpu_xir_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic [EXT_W-1:0]   ext_raw, ext_rise;
  logic [CPU_N:0]     por_req, por_done;
  logic [CPU_N-1:0]   xir_req, xir_done, cpu_por_act;
  logic               synth_trig, wd_en;
  logic [CAUSE_W-1:0] cause_evt, cause_q;
  logic [XSRC_W-1:0]  xir_evt, xsrc_q;
  logic               sys_trig, sys_act, xir_all, wdog_rise;

  always_comb begin
    ext_raw = '0;
    ext_raw[E_WDOG]    = wdog_expire_i;
    ext_raw[E_BTN]     = btn_rst_i;
    ext_raw[E_DBG]     = dbg_rst_i;
    ext_raw[E_REMOTE]  = remote_rst_i;
    ext_raw[E_DBG_XIR] = dbg_xir_i;
    ext_raw[E_BTN_XIR] = btn_xir_i;
    ext_raw[E_FATAL0 +: FATAL_N] = fatal_err_i;
  end

  rstctl_edge #(.W(EXT_W)) u_edge (
    .clk(clk), .rst_n(rst_n_int), .d(ext_raw), .rise(ext_rise)
  );

  rstctl_regs u_regs (
    .clk(clk), .rst_n(rst_n_int), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .por_done(por_done), .xir_done(xir_done),
    .cause_q(cause_q), .xsrc_q(xsrc_q), .por_req(por_req), .xir_req(xir_req),
    .synth_trig(synth_trig), .wd_en(wd_en), .reg_rdata(reg_rdata)
  );

  assign wdog_rise = ext_rise[E_WDOG];

  always_comb begin
    cause_evt = '0;
    cause_evt[CPU_N-1:0]             = por_req[CPU_N-1:0];
    cause_evt[C_SOFT_SYS]            = por_req[CPU_N];
    cause_evt[C_DBG]                 = ext_rise[E_DBG];
    cause_evt[C_BTN]                 = ext_rise[E_BTN];
    cause_evt[C_FATAL0 +: FATAL_N]   = ext_rise[E_FATAL0 +: FATAL_N];
    cause_evt[C_SYNTH]               = synth_trig;
    cause_evt[C_WDOG]                = wdog_rise & wd_en;
    cause_evt[C_REMOTE]              = ext_rise[E_REMOTE];
    xir_evt = '0;
    xir_evt[CPU_N-1:0]               = xir_req;
    xir_evt[X_DBG]                   = ext_rise[E_DBG_XIR];
    xir_evt[X_BTN]                   = ext_rise[E_BTN_XIR];
  end

  assign sys_trig = |cause_evt[CAUSE_W-1:C_SOFT_SYS];
  assign xir_all  = xir_evt[X_DBG] | xir_evt[X_BTN];

  rstctl_capture u_cap (
    .clk(clk), .rst_n(rst_n_int), .cause_evt(cause_evt), .xir_evt(xir_evt),
    .cause_q(cause_q), .xsrc_q(xsrc_q)
  );

  rstctl_pulse #(.LEN(PULSE_LEN)) u_sys (
    .clk(clk), .rst_n(rst_n_int), .trig(sys_trig),
    .active(sys_act), .done(por_done[CPU_N])
  );

  for (genvar g = 0; g < CPU_N; g++) begin : g_cpu
    rstctl_pulse #(.LEN(PULSE_LEN)) u_por (
      .clk(clk), .rst_n(rst_n_int), .trig(por_req[g]),
      .active(cpu_por_act[g]), .done(por_done[g])
    );
    rstctl_pulse #(.LEN(PULSE_LEN)) u_xir (
      .clk(clk), .rst_n(rst_n_int), .trig(xir_req[g] | xir_all),
      .active(cpu_xir_o[g]), .done(xir_done[g])
    );
    assign cpu_por_o[g] = cpu_por_act[g] | sys_act;
  end

  assign sys_por_o = sys_act;

  AST_SOFT_SYS_PENDING: assert property (@(posedge clk) disable iff (!rst_n_int)
    ((reg_addr == A_SOFT_POR) && reg_rdata[CPU_N]) |-> sys_por_o); // R4
  AST_WD_GATED: assert property (@(posedge clk) disable iff (!rst_n_int)
    (wdog_rise && !wd_en && !sys_por_o && !(|cause_evt[C_SYNTH:C_SOFT_SYS]) && !cause_evt[C_REMOTE])
      |=> !sys_por_o); // R5
  AST_XIR_ALL: assert property (@(posedge clk) disable iff (!rst_n_int)
    xir_all |=> (&cpu_xir_o)); // R9
  AST_SYS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n_int)
    sys_trig |=> (sys_por_o && !cause_q[C_PWR])); // R6
endmodule

// File: tb/rstctl_tb_top.sv
module rstctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic [12:0] ext = '0;
  logic [3:0]  cpu_por_o, cpu_xir_o;
  logic        sys_por_o;
  int          nchk = 0;
  int          nerr = 0;
  bit          done_flag = 0;

  always #4 clk = ~clk;

  rstctl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wdog_expire_i(ext[0]), .btn_rst_i(ext[1]), .dbg_rst_i(ext[2]),
    .remote_rst_i(ext[10]), .fatal_err_i(ext[9:3]),
    .dbg_xir_i(ext[11]), .btn_xir_i(ext[12]),
    .cpu_por_o(cpu_por_o), .sys_por_o(sys_por_o), .cpu_xir_o(cpu_xir_o)
  );

  localparam logic [12:0] P_WDOG = 13'h0001;
  localparam logic [12:0] P_BTN  = 13'h0002;
  localparam logic [12:0] P_DBG  = 13'h0004;
  localparam logic [12:0] P_RMT  = 13'h0400;
  localparam logic [12:0] P_DXIR = 13'h0800;
  localparam logic [12:0] P_BXIR = 13'h1000;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'd0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
    @(negedge clk);
  endtask

  task automatic pin(input logic [12:0] m);
    ext = m;
    @(negedge clk);
    ext = '0;
  endtask

  function automatic logic sel(input int w);
    case (w)
      0: return |cpu_por_o;
      1: return sys_por_o;
      default: return |cpu_xir_o;
    endcase
  endfunction

  task automatic width(input int w, output int n);
    n = 0;
    while (sel(w) && n < 40) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic settle();
    while (|cpu_por_o || sys_por_o || |cpu_xir_o) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, R11 cause layout
    chk("R1 por", {27'd0, sys_por_o, cpu_por_o}, 0);
    chk("R1 xir", cpu_xir_o, 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk(a == 4 ? "R1 R11 cause0" : "R1 reg", v, a == 4 ? 8'h80 : 8'h00);
    end

    // R2 R4 per-processor soft reset sweep
    for (int m = 1; m < 16; m++) begin
      wr(3'd0, 8'(m));
      chk("R2 cpu_por mask", cpu_por_o, m);
      chk("R2 sys idle", sys_por_o, 0);
      width(0, n);
      chk("R2 width", n, 16);
      rd(3'd0, v); chk("R4 self-clear", v, 0);
      rd(3'd4, v); chk("R2 cause0", v, m);
      rd(3'd5, v); chk("R11 cause1", v, 0);
      settle();
    end

    // R3 soft system reset
    wr(3'd0, 8'h10);
    chk("R3 cpu all", cpu_por_o, 4'hF);
    chk("R3 sys", sys_por_o, 1);
    rd(3'd0, v); chk("R4 readback sys", v, 8'h10);
    width(1, n); chk("R3 width", n, 15);
    rd(3'd0, v); chk("R4 sys cleared", v, 0);
    rd(3'd4, v); chk("R3 cause0", v, 8'h10);
    settle();

    // R4 writing 0 does not cancel
    wr(3'd0, 8'h01);
    wr(3'd0, 8'h00);
    chk("R4 still on", cpu_por_o, 4'h1);
    width(0, n); chk("R4 no cancel width", n, 15);
    settle();

    // R12 retrigger restarts
    wr(3'd0, 8'h02);
    repeat (4) @(negedge clk);
    wr(3'd0, 8'h02);
    width(0, n); chk("R12 restart width", n, 16);
    settle();

    // R5 watchdog disabled is ignored
    pin(P_WDOG);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      if (sys_por_o || cpu_por_o != 0) bad++;
      @(negedge clk);
    end
    chk("R5 ignored outputs", bad, 0);
    rd(3'd4, v); chk("R5 ignored cause0", v, 8'h02);
    rd(3'd6, v); chk("R5 ignored cause2", v, 0);

    // R5 watchdog enabled, R10 reserved
    wr(3'd2, 8'hFF);
    rd(3'd2, v); chk("R10 wd reserved", v, 8'h01);
    pin(P_WDOG);
    chk("R5 sys", sys_por_o, 1);
    width(1, n); chk("R5 width", n, 16);
    rd(3'd6, v); chk("R5 R11 cause2", v, 8'h01);
    rd(3'd4, v); chk("R5 cause0 replaced", v, 0);
    settle();

    // R6 external requests
    pin(P_BTN);
    chk("R6 btn sys", sys_por_o, 1);
    settle();
    rd(3'd4, v); chk("R6 btn cause", v, 8'h40);
    rd(3'd6, v); chk("R6 btn cause2", v, 0);
    pin(P_DBG);
    width(1, n); chk("R6 dbg width", n, 16);
    settle();
    rd(3'd4, v); chk("R6 dbg cause", v, 8'h20);
    pin(P_RMT);
    chk("R6 remote sys", sys_por_o, 1);
    settle();
    rd(3'd6, v); chk("R6 remote cause2", v, 8'h02);
    for (int k = 0; k < 7; k++) begin
      pin(13'(1) << (3 + k));
      chk("R6 fatal sys", sys_por_o, 1);
      settle();
      rd(3'd5, v); chk("R6 fatal cause1", v, 1 << k);
      rd(3'd4, v); chk("R6 fatal cause0", v, 0);
    end
    pin(P_BTN | P_DBG);
    settle();
    rd(3'd4, v); chk("R6 simultaneous", v, 8'h60);

    // R7 synthesizer load
    wr(3'd3, 8'h01);
    chk("R7 unarmed", sys_por_o, 0);
    rd(3'd3, v); chk("R7 readback", v, 8'h01);
    rd(3'd4, v); chk("R7 unarmed cause", v, 8'h60);
    wr(3'd3, 8'h00);
    wr(3'd3, 8'h81);
    chk("R7 armed sys", sys_por_o, 1);
    width(1, n); chk("R7 width", n, 16);
    rd(3'd5, v); chk("R7 cause1", v, 8'h80);
    settle();
    wr(3'd3, 8'hFF);
    chk("R7 load held", sys_por_o, 0);
    rd(3'd3, v); chk("R10 synth reserved", v, 8'h81);

    // R8 soft interrupt-reset sweep
    for (int m = 1; m < 16; m++) begin
      wr(3'd1, 8'(m));
      chk("R8 xir mask", cpu_xir_o, m);
      chk("R8 por idle", cpu_por_o, 0);
      rd(3'd1, v); chk("R4 xir readback", v, m);
      width(2, n); chk("R8 width", n, 15);
      rd(3'd1, v); chk("R4 xir cleared", v, 0);
      rd(3'd7, v); chk("R8 xsrc", v, m);
      settle();
    end

    // R9 broadcast interrupt-resets
    pin(P_DXIR);
    chk("R9 dbg all", cpu_xir_o, 4'hF);
    width(2, n); chk("R9 width", n, 16);
    rd(3'd7, v); chk("R9 dbg src", v, 8'h10);
    settle();
    pin(P_BXIR);
    chk("R9 btn all", cpu_xir_o, 4'hF);
    settle();
    rd(3'd7, v); chk("R9 btn src", v, 8'h20);

    // R10 read-only and reserved writes
    for (int a = 4; a < 8; a++) wr(3'(a), 8'hFF);
    rd(3'd5, v); chk("R10 cause1 ro", v, 8'h80);
    rd(3'd7, v); chk("R10 xsrc ro", v, 8'h20);
    wr(3'd0, 8'hE0);
    chk("R10 por reserved", {27'd0, sys_por_o, cpu_por_o}, 0);
    rd(3'd0, v); chk("R10 por rd", v, 0);
    wr(3'd1, 8'hF0);
    chk("R10 xir reserved", cpu_xir_o, 0);
    rd(3'd1, v); chk("R10 xir rd", v, 0);

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule